// File: doc/BRIEF.md
# Dual-Channel Memory Channel Selector

This block sits in front of a two-channel memory controller and decides, for each request, which channel serves it. The channel is not a single address bit. Address bit 6 forms the base, so neighbouring 64-byte blocks alternate between channels. Higher address bits may then be XORed into it. Which bits are used depends on three things: the requester (processor or graphics engine), the tiling layout of the surface being accessed, and a channel randomization option.

Each request is an address with its requester and tiling tags, offered on a ready/valid handshake. The decision is registered and offered on a second ready/valid handshake one cycle later. Configuration inputs describe the memory population: addressing mode, randomization disable, randomization bit choice and a stacked-rank flag. They are held in a shadow copy while a result is waiting, so a configuration change never alters a request that has already been accepted.

Top module: `chan_sel`

## Requirements
- R1: When the addressing mode is single channel (0), asymmetric dual channel (1) or the reserved code 3, every result is channel 0.
- R2: In interleaved mode (2) with the stacked flag clear and randomization disabled (xor_dis = 1), a processor request (req_gfx = 0) selects channel equal to address bit 6.
- R3: In interleaved mode with the stacked flag clear and randomization enabled (xor_dis = 0), a processor request selects bit 6 XOR bit 11 when xor_hi = 0, and bit 6 XOR bit 17 when xor_hi = 1.
- R4: In interleaved mode with the stacked flag clear, a graphics request (req_gfx = 1) to an X-tiled surface (tile code 1) selects bit 6 XOR bit 9 XOR bit 10, regardless of the randomization settings.
- R5: In interleaved mode with the stacked flag clear, a graphics request to a Y-tiled surface (tile code 2) selects bit 6 XOR bit 9, regardless of the randomization settings.
- R6: A graphics request to an untiled surface (tile code 0, or the reserved code 3) decodes exactly as a processor request under the same configuration.
- R7: In interleaved mode with the stacked flag set, every request selects address bit 6, whatever the requester, tiling and randomization settings.
- R8: After reset, out_valid is 0. A request accepted at a clock edge (req_valid and req_ready both high) makes out_valid 1 with its channel at that same edge, so the result is visible in the following cycle.
- R9: While out_valid is 1 and out_ready is 0, req_ready is 0, and out_valid and out_chan hold their values.
- R10: A configuration change made while a result is pending (out_valid = 1) has no effect on any request accepted before out_valid next returns to 0. It applies to the first request accepted after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_addr | input | AW | Physical request address |
| req_gfx | input | 1 | 1 = graphics engine, 0 = processor |
| req_tile | input | 2 | 0 untiled, 1 X-tiled, 2 Y-tiled, 3 treated as untiled |
| cfg_mode | input | 2 | 0 single, 1 asymmetric, 2 interleaved, 3 reserved |
| cfg_xor_dis | input | 1 | 1 disables channel randomization |
| cfg_xor_hi | input | 1 | Randomization bit: 0 selects bit 11, 1 selects bit 17 |
| cfg_flex | input | 1 | Stacked-rank population flag |
| out_valid | output | 1 | Channel decision available |
| out_ready | input | 1 | Consumer takes the decision |
| out_chan | output | 1 | Selected channel |

## Verification
A wrong decode term shows up on out_chan in the cycle right after the request is accepted, for only those address patterns that flip the missing or extra bit. For this reason the sweep toggles bits 6, 9, 10, 11 and 17 in every combination, under every configuration. A shadow configuration that tracks the live inputs at the wrong time only shows once a request is accepted behind a stalled result. That case is set up directly: the configuration is changed under a stall and the channel of the next request is compared.

// File: rtl/chan_sel.sv
module chan_sel #(
  parameter int AW      = 32,
  parameter int BLK_BIT = 6,
  parameter int XT0_BIT = 9,
  parameter int XT1_BIT = 10,
  parameter int RLO_BIT = 11,
  parameter int RHI_BIT = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_gfx,
  input  logic [1:0]    req_tile,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_xor_dis,
  input  logic          cfg_xor_hi,
  input  logic          cfg_flex,
  output logic          out_valid,
  input  logic          out_ready,
  output logic          out_chan
);

  localparam logic [1:0] MODE_ILV = 2'd2;
  localparam logic [1:0] TILE_X   = 2'd1;
  localparam logic [1:0] TILE_Y   = 2'd2;

  logic [1:0] sh_mode;
  logic       sh_xdis, sh_xhi, sh_flex;
  logic [1:0] e_mode;
  logic       e_xdis, e_xhi, e_flex;
  logic       accept, rnd, cpu_ch, nxt_ch;

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  assign e_mode = out_valid ? sh_mode : cfg_mode;
  assign e_xdis = out_valid ? sh_xdis : cfg_xor_dis;
  assign e_xhi  = out_valid ? sh_xhi  : cfg_xor_hi;
  assign e_flex = out_valid ? sh_flex : cfg_flex;

  assign rnd    = !e_xdis && (e_xhi ? req_addr[RHI_BIT] : req_addr[RLO_BIT]);
  assign cpu_ch = req_addr[BLK_BIT] ^ rnd;

  always_comb begin
    nxt_ch = 1'b0;
    if (e_mode == MODE_ILV) begin
      if (e_flex)
        nxt_ch = req_addr[BLK_BIT];
      else if (req_gfx && req_tile == TILE_X)
        nxt_ch = req_addr[BLK_BIT] ^ req_addr[XT0_BIT] ^ req_addr[XT1_BIT];
      else if (req_gfx && req_tile == TILE_Y)
        nxt_ch = req_addr[BLK_BIT] ^ req_addr[XT0_BIT];
      else
        nxt_ch = cpu_ch;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_mode <= 2'd0;
      sh_xdis <= 1'b1;
      sh_xhi  <= 1'b0;
      sh_flex <= 1'b0;
    end else if (!out_valid) begin
      sh_mode <= cfg_mode;
      sh_xdis <= cfg_xor_dis;
      sh_xhi  <= cfg_xor_hi;
      sh_flex <= cfg_flex;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_chan  <= nxt_ch;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  AST_NO_INTERLEAVE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && e_mode != MODE_ILV |=> out_chan == 1'b0); // R1
  AST_CPU_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_gfx && e_mode == MODE_ILV && !e_flex && e_xdis
    |=> out_chan == $past(req_addr[BLK_BIT])); // R2
  AST_X_TILE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_gfx && req_tile == TILE_X && e_mode == MODE_ILV && !e_flex
    |=> out_chan == $past(req_addr[BLK_BIT] ^ req_addr[XT0_BIT] ^ req_addr[XT1_BIT])); // R4
  AST_Y_TILE: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_gfx && req_tile == TILE_Y && e_mode == MODE_ILV && !e_flex
    |=> out_chan == $past(req_addr[BLK_BIT] ^ req_addr[XT0_BIT])); // R5
  AST_STACKED: assert property (@(posedge clk) disable iff (!rst_n)
    accept && e_mode == MODE_ILV && e_flex |=> out_chan == $past(req_addr[BLK_BIT])); // R7
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_chan)); // R9
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !req_ready); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> $stable(sh_mode) && $stable(sh_flex) && $stable(sh_xdis) && $stable(sh_xhi)); // R10

endmodule

// File: tb/chan_sel_bench.sv
module chan_sel_bench;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_gfx = 1'b0;
  logic [1:0]    req_tile = 2'd0;
  logic [1:0]    cfg_mode = 2'd0;
  logic          cfg_xor_dis = 1'b1;
  logic          cfg_xor_hi = 1'b0;
  logic          cfg_flex = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic          out_chan;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  chan_sel #(.AW(AW)) u_chan_sel (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_gfx(req_gfx), .req_tile(req_tile),
    .cfg_mode(cfg_mode), .cfg_xor_dis(cfg_xor_dis), .cfg_xor_hi(cfg_xor_hi),
    .cfg_flex(cfg_flex), .out_valid(out_valid), .out_ready(out_ready),
    .out_chan(out_chan)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit expect_ch(input logic [AW-1:0] a, input bit gfx, input int tile,
                                   input int mode, input bit xdis, input bit xhi, input bit flex);
    int b6, r;
    b6 = a[6];
    if (mode != 2) return 0;
    if (flex) return a[6];
    if (gfx && tile == 1) return (b6 + a[9] + a[10]) % 2;
    if (gfx && tile == 2) return (b6 + a[9]) % 2;
    r = xdis ? 0 : (xhi ? a[17] : a[11]);
    return (b6 + r) % 2;
  endfunction

  function automatic string tag(input int mode, input bit gfx, input int tile, input bit xdis, input bit flex);
    if (mode != 2) return "R1";
    if (flex) return "R7";
    if (gfx && tile == 1) return "R4";
    if (gfx && tile == 2) return "R5";
    if (gfx) return "R6";
    return xdis ? "R2" : "R3";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [AW-1:0] a;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R8 reset out_valid", out_valid, 0);
    check("R8 reset req_ready", req_ready, 1);
    rst_n = 1'b1;

    for (int c = 0; c < 32; c++) begin
      for (int g = 0; g < 2; g++) begin
        for (int t = 0; t < 4; t++) begin
          for (int p = 0; p < 32; p++) begin
            @(negedge clk);
            cfg_mode = c[1:0]; cfg_xor_dis = c[2]; cfg_xor_hi = c[3]; cfg_flex = c[4];
            a = 32'h5A3C_E1B7 ^ (32'(c * 7919 + p * 104729 + t * 31));
            a[6] = p[0]; a[9] = p[1]; a[10] = p[2]; a[11] = p[3]; a[17] = p[4];
            req_addr = a; req_gfx = g[0]; req_tile = t[1:0]; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check("R8 valid after accept", out_valid, 1);
            check(tag(c % 4, g[0], t, c[2], c[4]), out_chan,
                  expect_ch(a, g[0], t, c % 4, c[2], c[3], c[4]));
          end
        end
      end
    end

    // R9 / R10: stall, then change configuration under the stall
    @(negedge clk);
    out_ready = 1'b0;
    cfg_mode = 2'd2; cfg_flex = 1'b0; cfg_xor_dis = 1'b1;
    req_addr = 32'h0000_0040; req_gfx = 1'b0; req_tile = 2'd0; req_valid = 1'b1;
    @(negedge clk);
    check("R9 stalled valid", out_valid, 1);
    check("R9 stalled channel", out_chan, 1);
    cfg_mode = 2'd0;
    req_addr = 32'h0000_0040;
    @(negedge clk);
    check("R9 req_ready low while stalled", req_ready, 0);
    check("R9 hold valid", out_valid, 1);
    check("R9 hold channel", out_chan, 1);
    out_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 old cfg for request taken behind stall", out_chan, 1);
    @(negedge clk);
    check("R8 drains", out_valid, 0);
    req_addr = 32'h0000_0040; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R10 new cfg after idle", out_chan, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule